// File: doc/BRIEF.md
# Timer Capture/Compare Output Unit

A 16-bit timer counter with two capture/compare channels. Channel 0 holds the period value. Channel x is a general channel. The counter advances once for each single-cycle timer tick. It runs in one of four count modes: halted, up, free-running or up/down. Each channel compares its register with the counter, or captures the counter on a rising edge of its capture input. Each channel also drives a pulse-width output pin through an eight-mode output unit. That unit sets, toggles or clears the pin from the equality of its own channel and the equality of the period channel.

Software talks to the block through a simple write strobe with a 3-bit address. Through it, software loads the counter and the compare values, picks the count mode, and sets each channel's output mode, capture select and static output bit. Three interrupt flags are kept: period-channel event, channel-x event and overflow. A vector read strobe reports the highest-priority pending flag and clears that flag and no other. The pin, flag and capture timing follow tight rules. The pin reacts to the counter value held before the tick. Up mode uses a delayed period equality. Up/down mode has a zero-compare special case. A capture raises its flag in the same cycle as the captured data.

Top module: `tmr_ccu`

## Requirements
- R1: After reset the counter, both compare values, all flags, the vector code and both pins are 0, and the count mode is halted.
- R2: Address 0 with wr_data[1:0] sets the count mode, and the counter moves once per cycle with tick high. The modes are: 0 halts. 1 counts up to the period value (address 2) and then returns to 0. 2 runs free and wraps from all-ones to 0. 3 counts up to the period and back down to 0. irq_flags[2] (overflow) is set when mode 1 returns to 0, when mode 2 wraps, and when mode 3 steps from 1 to 0.
- R3: A write to address 1 makes the counter read exactly the written value in the next cycle, even if tick is high in the same cycle. That tick is absorbed. The following tick advances from the loaded value.
- R4: Channel control sits at address 4 (channel 0) and address 5 (channel x). In it, wr_data[2:0] is the output mode, bit 3 selects capture, and bit 4 is the static output bit. Mode 0 makes the pin follow the static bit. Mode 1 sets the pin on own equality, mode 4 toggles it, and mode 5 clears it. With no equality the pin holds.
- R5: Modes 2 and 6 toggle on own equality alone. Modes 3 and 7 set (3) or clear (7) on own equality alone. On period equality alone, modes 2 and 3 clear the pin and modes 6 and 7 set it. With both equalities, modes 2 and 3 give 1 and modes 6 and 7 give 0.
- R6: A pin in modes 1 to 7 changes only at an edge where the counter advances. It uses the equalities of the counter value before that advance. Channel x compares with the value at address 3.
- R7: In up mode, the period equality used by channel x is the one from the previous advance, not the current one.
- R8: In up/down mode, if the channel-x compare value equals the counter and the counter is 0, mode 2 drives the pin to 0 and mode 6 drives it to 1 instead of toggling.
- R9: In capture mode, the first advance after a synchronised rising edge of the capture input copies the counter into the channel register. The channel flag rises at that same edge and not before.
- R10: A pending capture is dropped once it is taken, so one input edge yields one capture. It is also dropped when the channel is switched to compare mode.
- R11: iv_code is 1 when irq_flags[0] is set. Otherwise it is 2 when irq_flags[1] is set, 3 when irq_flags[2] is set, and 0 when none is set. An iv_rd strobe clears only the flag named by the code.
- R12: A flag set condition in the same cycle as a vector read that clears that flag leaves the flag set. The same holds for a write to that channel's compare value in that cycle.
- R13: With tick held high for many cycles, the overflow flag is set only at wrap advances and never by the held level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer advance enable, one cycle per timer clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| iv_rd | input | 1 | Vector read strobe, clears the reported flag |
| cap_in | input | 2 | Capture inputs, bit 0 channel 0, bit 1 channel x |
| iv_code | output | 2 | Highest-priority pending flag code |
| irq_flags | output | 3 | Flags: 0 period channel, 1 channel x, 2 overflow |
| cnt_val | output | 16 | Counter value |
| ccr0_val | output | 16 | Period channel register |
| ccrx_val | output | 16 | Channel-x register |
| pwm_out | output | 2 | Output pins, bit 0 channel 0, bit 1 channel x |

## Verification
Three kinds of event can land in the same cycle as a flag update: a software access, a tick-driven flag set, and a counter load. A flag set can meet a vector read that clears the same flag, or a write to the channel's compare value. A counter load can meet a tick. The bench drives the strobe and tick in one cycle. It then expects the flag to stay set, the compare value to take the new data, and the counter to show the loaded value with no extra step. A cycle-level model in the bench, built from the requirements, judges every other tick in sweeps over count modes, output modes and equality combinations.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    CM_HALT = 2'd0,
    CM_UP   = 2'd1,
    CM_FREE = 2'd2,
    CM_UPDN = 2'd3
  } cmode_t;

  typedef struct packed {
    logic       outbit;
    logic       cap;
    logic [2:0] omode;
  } chcfg_t;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CNT  = 3'd1;
  localparam logic [2:0] A_CCR0 = 3'd2;
  localparam logic [2:0] A_CFG0 = 3'd4;

  // next pin value from own equality (ex) and period equality (e0)
  function automatic logic out_law(input logic [2:0] m, input logic cur,
                                   input logic e0, input logic ex);
    logic r;
    r = cur;
    case (m)
      3'd1: if (ex) r = 1'b1;
      3'd2: if (ex && e0) r = 1'b1; else if (ex) r = ~cur; else if (e0) r = 1'b0;
      3'd3: if (ex) r = 1'b1; else if (e0) r = 1'b0;
      3'd4: if (ex) r = ~cur;
      3'd5: if (ex) r = 1'b0;
      3'd6: if (ex && e0) r = 1'b0; else if (ex) r = ~cur; else if (e0) r = 1'b1;
      3'd7: if (ex) r = 1'b0; else if (e0) r = 1'b1;
      default: r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_cnt.sv
module tmr_cnt
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  cmode_t       cmode,
  input  logic [W-1:0] period,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         dn_q;
  logic [W-1:0] nxt;
  logic         nxt_dn;
  logic         wrap_c;

  always_comb begin
    nxt    = cnt;
    nxt_dn = dn_q;
    wrap_c = 1'b0;
    case (cmode)
      CM_UP: begin
        if (cnt >= period) begin
          nxt    = '0;
          wrap_c = 1'b1;
        end else nxt = cnt + ONE;
      end
      CM_FREE: begin
        nxt    = cnt + ONE;
        wrap_c = &cnt;
      end
      CM_UPDN: begin
        if (!dn_q) begin
          if (cnt >= period) begin
            nxt_dn = 1'b1;
            nxt    = (cnt == '0) ? '0 : cnt - ONE;
          end else nxt = cnt + ONE;
        end else if (cnt == '0) begin
          nxt_dn = 1'b0;
          nxt    = (period == '0) ? '0 : ONE;
        end else begin
          nxt    = cnt - ONE;
          wrap_c = (cnt == ONE);
        end
      end
      default: nxt = cnt;
    endcase
  end

  assign wrap = adv & wrap_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      dn_q <= 1'b0;
    end else if (ld) begin
      cnt <= ld_val;
    end else if (adv) begin
      cnt  <= nxt;
      dn_q <= nxt_dn;
    end
  end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  chcfg_t       cfg,
  input  logic [W-1:0] cnt,
  input  logic         eq0_in,
  input  logic         updn,
  input  logic         ccr_ld,
  input  logic [W-1:0] ccr_wdata,
  input  logic         cap_edge,
  output logic [W-1:0] ccr,
  output logic         equ,
  output logic         hit,
  output logic         take,
  output logic         pend,
  output logic         pin
);
  logic zero_hit;
  logic pin_nxt;

  assign equ      = (cnt == ccr);
  assign take     = adv & cfg.cap & pend;
  assign hit      = cfg.cap ? take : (adv & equ);
  assign zero_hit = updn & (cnt == '0) & equ;

  always_comb begin
    if (zero_hit && cfg.omode == 3'd2)      pin_nxt = 1'b0;
    else if (zero_hit && cfg.omode == 3'd6) pin_nxt = 1'b1;
    else pin_nxt = out_law(cfg.omode, pin, eq0_in, equ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr  <= '0;
      pend <= 1'b0;
      pin  <= 1'b0;
    end else begin
      if (take)        ccr <= cnt;
      else if (ccr_ld) ccr <= ccr_wdata;
      pend <= cfg.cap ? ((pend & ~take) | cap_edge) : 1'b0;
      if (cfg.omode == 3'd0) pin <= cfg.outbit;
      else if (adv)          pin <= pin_nxt;
    end
  end

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NF = 3,
  localparam int CW = $clog2(NF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic          rd,
  output logic [NF-1:0] flags,
  output logic [CW-1:0] code
);
  logic [NF-1:0] clr;

  always_comb begin
    code = '0;
    for (int i = NF - 1; i >= 0; i--)
      if (flags[i]) code = CW'(i + 1);
  end

  always_comb begin
    clr = '0;
    if (rd && code != '0) clr[code - CW'(1)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end

endmodule

// File: rtl/tmr_ccu.sv
module tmr_ccu
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         iv_rd,
  input  logic [1:0]   cap_in,
  output logic [1:0]   iv_code,
  output logic [2:0]   irq_flags,
  output logic [W-1:0] cnt_val,
  output logic [W-1:0] ccr0_val,
  output logic [W-1:0] ccrx_val,
  output logic [1:0]   pwm_out
);
  localparam int NCH = 2;

  cmode_t       cmode_q;
  chcfg_t       cfg_q   [NCH];
  logic [W-1:0] ccr     [NCH];
  logic         equ     [NCH];
  logic         hit     [NCH];
  logic         take    [NCH];
  logic         pend    [NCH];
  logic         cedge   [NCH];
  logic [1:0]   s1, s2, s3;
  logic         eq0_d;
  logic         cnt_ld;
  logic         adv;
  logic         wrap;

  assign cnt_ld = wr_en && (wr_addr == A_CNT);
  assign adv    = tick && !cnt_ld && (cmode_q != CM_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmode_q <= CM_HALT;
      s1      <= '0;
      s2      <= '0;
      s3      <= '0;
      eq0_d   <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_MODE) cmode_q <= cmode_t'(wr_data[1:0]);
      s1 <= cap_in;
      s2 <= s1;
      s3 <= s2;
      if (adv) eq0_d <= equ[0];
    end
  end

  tmr_cnt #(.W(W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cmode(cmode_q), .period(ccr[0]),
    .ld(cnt_ld), .ld_val(wr_data), .cnt(cnt_val), .wrap(wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic eq0_sel;
    if (i == 0) begin : g_per
      assign eq0_sel = equ[0];
    end else begin : g_gen
      assign eq0_sel = (cmode_q == CM_UP) ? eq0_d : equ[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= '0;
      else if (wr_en && wr_addr == A_CFG0 + 3'(i)) cfg_q[i] <= chcfg_t'(wr_data[4:0]);
    end

    assign cedge[i] = s2[i] & ~s3[i];

    tmr_chan #(.W(W)) ch_i (
      .clk(clk), .rst_n(rst_n), .adv(adv), .cfg(cfg_q[i]), .cnt(cnt_val),
      .eq0_in(eq0_sel), .updn(cmode_q == CM_UPDN),
      .ccr_ld(wr_en && wr_addr == A_CCR0 + 3'(i)), .ccr_wdata(wr_data),
      .cap_edge(cedge[i]), .ccr(ccr[i]), .equ(equ[i]), .hit(hit[i]),
      .take(take[i]), .pend(pend[i]), .pin(pwm_out[i])
    );
  end

  assign ccr0_val = ccr[0];
  assign ccrx_val = ccr[1];

  tmr_irq #(.NF(3)) irq_i (
    .clk(clk), .rst_n(rst_n), .set({wrap, hit[1], hit[0]}), .rd(iv_rd),
    .flags(irq_flags), .code(iv_code)
  );

endmodule

// File: rtl/tmr_ccu_chk.sv
module tmr_ccu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         adv,
  input logic         cnt_ld,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] cnt_val,
  input logic [W-1:0] ccrx_val,
  input logic         take_x,
  input logic         pend_x,
  input logic         edge_x,
  input logic [2:0]   irq_flags,
  input logic [1:0]   iv_code,
  input logic         iv_rd,
  input logic         wrap,
  input logic [1:0]   cmode,
  input logic [2:0]   modex,
  input logic         capx,
  input logic         outbitx,
  input logic         pwm_x
);

  p_load_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld |=> cnt_val == $past(wr_data));

  p_cap_same_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_x |=> (irq_flags[1] && ccrx_val == $past(cnt_val)));

  p_pend_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_x && !edge_x) |=> !pend_x);

  p_pend_cmp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !capx |=> !pend_x);

  p_ovf_wrap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flags[2] && !$past(irq_flags[2])) |-> $past(wrap));

  p_iv_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_code == 2'd0) == (irq_flags == 3'd0));

  p_iv_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flags[0] |-> iv_code == 2'd1);

  p_flag_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flags[1] && !(iv_rd && iv_code == 2'd2)) |=> irq_flags[1]);

  p_zero_case_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cmode == 2'd3 && cnt_val == '0 && ccrx_val == '0 && !capx && modex == 3'd2)
    |=> !pwm_x);

  p_static_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (modex == 3'd0) |=> pwm_x == $past(outbitx));

endmodule

bind tmr_ccu tmr_ccu_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .adv(adv), .cnt_ld(cnt_ld), .wr_data(wr_data),
  .cnt_val(cnt_val), .ccrx_val(ccrx_val), .take_x(take[1]), .pend_x(pend[1]),
  .edge_x(cedge[1]), .irq_flags(irq_flags), .iv_code(iv_code), .iv_rd(iv_rd),
  .wrap(wrap), .cmode(cmode_q), .modex(cfg_q[1].omode), .capx(cfg_q[1].cap),
  .outbitx(cfg_q[1].outbit), .pwm_x(pwm_out[1])
);

// File: tb/tmr_ccu_tb.sv
module tmr_ccu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        iv_rd = 1'b0;
  logic [1:0]  cap_in = '0;
  logic [1:0]  iv_code;
  logic [2:0]  irq_flags;
  logic [15:0] cnt_val, ccr0_val, ccrx_val;
  logic [1:0]  pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  tmr_ccu dut_i (.*);

  always #5 clk = ~clk;

  // bench model state
  logic [15:0] m_cnt = 0, m_ccr0 = 0, m_ccrx = 0;
  logic        m_dn = 0, m_capx = 0, m_bit = 0, m_outx = 0, m_e0d = 0;
  logic [2:0]  m_f = 0;
  int          m_cm = 0, m_mx = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_out(int m, logic cur, logic e0, logic ex);
    logic p;
    int   b;
    if (m == 4) return ex ? ~cur : cur;
    p = (m < 4);
    b = m % 4;
    if (ex && e0) return p;
    if (ex) return (b == 2) ? ~cur : p;
    if (e0) return (b == 1) ? cur : ~p;
    return cur;
  endfunction

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    @(negedge clk);
  endtask

  task automatic set_cm(int m);   wr(3'd0, 16'(m)); m_cm = m;   endtask
  task automatic ld_cnt(logic [15:0] v); wr(3'd1, v); m_cnt = v; endtask
  task automatic set_ccr0(logic [15:0] v); wr(3'd2, v); m_ccr0 = v; endtask
  task automatic set_ccrx(logic [15:0] v); wr(3'd3, v); m_ccrx = v; endtask
  task automatic set_chx(logic b, logic c, int m);
    wr(3'd5, {11'd0, b, c, 3'(m)});
    m_bit = b; m_capx = c; m_mx = m;
    if (m == 0) m_outx = b;
  endtask

  task automatic model_step();
    logic e0, ex, e0u;
    if (m_cm == 0) return;
    e0  = (m_cnt == m_ccr0);
    ex  = (m_cnt == m_ccrx);
    e0u = (m_cm == 1) ? m_e0d : e0;
    if (m_mx != 0) begin
      if (m_cm == 3 && m_cnt == 0 && ex && m_mx == 2)      m_outx = 0;
      else if (m_cm == 3 && m_cnt == 0 && ex && m_mx == 6) m_outx = 1;
      else m_outx = exp_out(m_mx, m_outx, e0u, ex);
    end
    if (e0) m_f[0] = 1;
    if (ex && !m_capx) m_f[1] = 1;
    m_e0d = e0;
    case (m_cm)
      1: if (m_cnt >= m_ccr0) begin m_cnt = 0; m_f[2] = 1; end else m_cnt = m_cnt + 1;
      2: begin if (m_cnt == 16'hFFFF) m_f[2] = 1; m_cnt = m_cnt + 1; end
      default: begin
        if (!m_dn) begin
          if (m_cnt >= m_ccr0) begin m_dn = 1; if (m_cnt != 0) m_cnt = m_cnt - 1; end
          else m_cnt = m_cnt + 1;
        end else if (m_cnt == 0) begin
          m_dn = 0; m_cnt = (m_ccr0 == 0) ? 16'd0 : 16'd1;
        end else begin
          if (m_cnt == 1) m_f[2] = 1;
          m_cnt = m_cnt - 1;
        end
      end
    endcase
  endtask

  task automatic cmp_all(string tag);
    check({tag, " counter"}, 32'(cnt_val), 32'(m_cnt));
    check({tag, " pin x"}, 32'(pwm_out[1]), 32'(m_outx));
    check({tag, " flags"}, 32'(irq_flags), 32'(m_f));
  endtask

  task automatic ptick();
    model_step();
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic mtick(string tag);
    ptick();
    cmp_all(tag);
  endtask

  task automatic drain(string tag);
    for (int k = 0; k < 4; k++) begin
      int e;
      e = m_f[0] ? 1 : m_f[1] ? 2 : m_f[2] ? 3 : 0;
      check({tag, " vector code"}, 32'(iv_code), 32'(e));
      if (e == 0) break;
      iv_rd = 1;
      @(negedge clk);
      iv_rd = 0;
      m_f[e-1] = 0;
      check({tag, " flag cleared"}, 32'(irq_flags), 32'(m_f));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 counter", 32'(cnt_val), 0);
    check("R1 flags", 32'(irq_flags), 0);
    check("R1 vector", 32'(iv_code), 0);
    check("R1 pins", 32'(pwm_out), 0);
    check("R1 compare values", {ccr0_val, ccrx_val}, 0);
    tick = 1; @(negedge clk); tick = 0;
    check("R1 halted counter", 32'(cnt_val), 0);

    // channel 0 static bit (R4)
    wr(3'd4, 16'h0010);
    check("R4 ch0 static bit", 32'(pwm_out[0]), 1);
    wr(3'd4, 16'h0000);
    check("R4 ch0 static bit low", 32'(pwm_out[0]), 0);

    // R2 sweep over count modes and output modes
    for (int cm = 1; cm <= 3; cm++) begin
      for (int mx = 0; mx < 8; mx++) begin
        logic [15:0] per;
        per = 16'(2 + mx % 3);
        set_cm(cm);
        set_ccr0(per);
        set_ccrx(16'(mx % (per + 1)));
        set_chx(mx[0], 1'b0, mx);
        ld_cnt(cm == 2 ? 16'hFFFE : 16'h0000);
        for (int t = 0; t < 2 * per + 3; t++) mtick("R2");
        drain("R11");
      end
    end

    // R4 R5 R6 exhaustive truth table in free-running mode
    set_cm(2);
    for (int mx = 1; mx < 8; mx++)
      for (int c = 0; c < 4; c++)
        for (int init = 0; init < 2; init++) begin
          logic e0, ex;
          string tg;
          e0 = c[0]; ex = c[1];
          tg = (mx == 1 || mx == 4 || mx == 5) ? "R4" : "R5";
          set_chx(init[0], 1'b0, 0);
          set_chx(init[0], 1'b0, mx);
          set_ccr0(16'd10);
          set_ccrx((ex && e0) ? 16'd10 : 16'd20);
          ld_cnt(e0 ? 16'd10 : ex ? 16'd20 : 16'd30);
          check("R6 pin holds before advance", 32'(pwm_out[1]), 32'(init));
          mtick(tg);
          drain("R11");
        end

    // R8 zero compare in up/down mode, plus free-running contrast
    set_ccr0(16'd5); set_ccrx(16'd0);
    set_cm(3);
    set_chx(1'b0, 1'b0, 0); set_chx(1'b0, 1'b0, 2); ld_cnt(0);
    mtick("R8");
    check("R8 toggle/reset forced low", 32'(pwm_out[1]), 0);
    set_chx(1'b1, 1'b0, 0); set_chx(1'b1, 1'b0, 6); ld_cnt(0);
    mtick("R8");
    check("R8 toggle/set forced high", 32'(pwm_out[1]), 1);
    set_cm(2);
    set_chx(1'b0, 1'b0, 0); set_chx(1'b0, 1'b0, 2); ld_cnt(0);
    mtick("R8");
    check("R8 free-run still toggles", 32'(pwm_out[1]), 1);
    drain("R11");

    // R7 delayed period equality in up mode
    set_cm(1); set_ccr0(16'd3); set_ccrx(16'd1);
    set_chx(1'b0, 1'b0, 0); set_chx(1'b0, 1'b0, 3); ld_cnt(0);
    for (int t = 0; t < 10; t++) mtick("R7");
    set_chx(1'b1, 1'b0, 0); set_chx(1'b1, 1'b0, 7); ld_cnt(0);
    for (int t = 0; t < 10; t++) mtick("R7");
    drain("R11");

    // R3 counter load coincident with a tick
    set_cm(2); set_ccr0(16'hFFFF); set_ccrx(16'hFFFF); set_chx(1'b0, 1'b0, 0);
    wr_en = 1; wr_addr = 3'd1; wr_data = 16'h1234; tick = 1;
    @(negedge clk);
    wr_en = 0; tick = 0; m_cnt = 16'h1234;
    check("R3 loaded value exact", 32'(cnt_val), 32'h1234);
    mtick("R3");
    check("R3 advances from load", 32'(cnt_val), 32'h1235);

    // R9 R10 capture on channel x
    set_chx(1'b0, 1'b1, 0); ld_cnt(16'd100);
    cap_in[1] = 1;
    repeat (4) @(negedge clk);
    check("R9 no flag before capture", 32'(irq_flags[1]), 0);
    check("R9 no data before capture", 32'(ccrx_val), 32'hFFFF);
    ptick(); m_f[1] = 1; m_ccrx = 16'd100;
    cmp_all("R9");
    check("R9 captured value", 32'(ccrx_val), 100);
    ptick();
    cmp_all("R10");
    check("R10 single capture per edge", 32'(ccrx_val), 100);
    drain("R11");
    cap_in[1] = 0;
    repeat (3) @(negedge clk);
    cap_in[1] = 1;
    repeat (4) @(negedge clk);
    set_chx(1'b0, 1'b0, 0);
    set_chx(1'b0, 1'b1, 0);
    ptick();
    cmp_all("R10");
    check("R10 compare select drops pending", 32'(ccrx_val), 100);
    cap_in[1] = 0;
    set_chx(1'b0, 1'b0, 0);

    // R11 priority of all three flags
    set_ccr0(16'hFFFF); set_ccrx(16'hFFFF); ld_cnt(16'hFFFF);
    mtick("R11");
    check("R11 three flags", 32'(irq_flags), 7);
    drain("R11");

    // R12 set together with compare write, then together with vector read
    set_ccrx(16'd50); ld_cnt(16'd50);
    model_step();
    wr_en = 1; wr_addr = 3'd3; wr_data = 16'd7; tick = 1;
    @(negedge clk);
    wr_en = 0; tick = 0; m_ccrx = 16'd7;
    cmp_all("R12");
    check("R12 compare write kept", 32'(ccrx_val), 7);
    ld_cnt(16'd7);
    check("R12 code before read", 32'(iv_code), 2);
    model_step();
    iv_rd = 1; tick = 1;
    @(negedge clk);
    iv_rd = 0; tick = 0;
    cmp_all("R12");
    check("R12 flag survives read", 32'(irq_flags[1]), 1);
    drain("R11");

    // R13 tick held high across several wraps
    set_cm(1); set_ccr0(16'd2); set_ccrx(16'd9); ld_cnt(0);
    for (int t = 0; t < 9; t++) ptick();
    cmp_all("R13");
    drain("R13");
    ld_cnt(0);
    ptick();
    cmp_all("R13");
    check("R13 no overflow without wrap", 32'(irq_flags[2]), 0);
    drain("R13");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule